// File: doc/BRIEF.md
# Windowed Carry-Less Multiplier

This block forms the 64-bit carry-less product of two 32-bit operands, that is, their product as polynomials over GF(2). Partial products are combined with XOR instead of addition. It is the inner kernel of binary-field arithmetic. Any reduction by a field polynomial is left to the logic that follows it.

The multiplier first clears the two most significant bits of operand A. From the remaining 30-bit value it forms eight XOR combinations of A, A shifted left by one and A shifted left by two. Operand B is then consumed three bits at a time, from the least significant end. Each 3-bit slice picks one of the eight combinations. That combination is shifted to the slice's bit offset and folded into a 64-bit accumulator by XOR, one slice per clock. A final correction cycle adds B shifted by 30 and by 31 for whichever of the two cleared bits of A were set.

A caller pulses `start` with both operands present. It then waits for the one-cycle `done` pulse and reads the product from two 32-bit words.

Top module: `clmul_win32`

## Requirements
- R1: After an operation, `{prod_hi, prod_lo}` equals the XOR, over every set bit i of B, of A shifted left by i. `prod_lo` holds bits 31..0 and `prod_hi` holds bits 63..32.
- R2: `done` is high for exactly one cycle. It rises 12 clock edges after the edge that accepts `start`: 11 slice cycles plus one correction cycle.
- R3: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `busy` and `done` are never high together.
- R4: `start` is ignored while `busy` is high. The running operation keeps its operands and its timing.
- R5: The operands are captured on the accepting edge. Later changes on `op_a` and `op_b` do not affect the result.
- R6: When bit 30 of A is set, the product includes B shifted left by 30.
- R7: When bit 31 of A is set, the product includes B shifted left by 31.
- R8: The top slice of B holds only bits 31 and 30, and it contributes at offset 30.
- R9: Asserting `rst_n` low clears the product words, `busy` and `done` at once, even in the middle of an operation.
- R10: The product holds its value from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op_a | input | 32 | Multiplicand A |
| op_b | input | 32 | Multiplier B |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| prod_lo | output | 32 | Product bits 31..0 |
| prod_hi | output | 32 | Product bits 63..32 |

## Verification
Every cycle, the assertions check the control sequence: the single-cycle `done` pulse, `busy` and `done` never overlapping, `done` following the fall of `busy`, and the slice counter staying in range. They also check that the captured operands hold while busy, that `start` during busy only advances the count, and that the product holds while idle. Only the bench scenarios can show that the arithmetic is correct. It compares results against a bit-serial reference over random and directed operands, including a set bit 30 or 31 of A and a top slice of B. It also measures the latency, and it scrambles the inputs and re-pulses `start` during an operation.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  // number of slices of width win needed to cover w bits
  function automatic int unsigned slice_count(int unsigned w, int unsigned win);
    return (w + win - 1) / win;
  endfunction
endpackage

// File: rtl/clmul_ctrl.sv
module clmul_ctrl #(
  parameter int unsigned NSLICE = 11,
  localparam int unsigned IDX_W = $clog2(NSLICE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             load,
  output logic             acc_en,
  output logic             fix_en,
  output logic [IDX_W-1:0] slice_idx
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    load   = start && !busy_q;
    acc_en = busy_q && (idx_q < IDX_W'(NSLICE));
    fix_en = busy_q && (idx_q == IDX_W'(NSLICE));
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = fix_en;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (acc_en) begin
      idx_d  = idx_q + 1'b1;
    end else if (fix_en) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign slice_idx = idx_q;

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(NSLICE));
  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && idx_q != IDX_W'(NSLICE)) |=> busy_q && (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/clmul_wintab.sv
module clmul_wintab #(
  parameter int unsigned OP_W = 32,
  parameter int unsigned WIN  = 3,
  localparam int unsigned NENT = 1 << WIN
) (
  input  logic [OP_W-1:0] a_low,
  input  logic [WIN-1:0]  sel,
  output logic [OP_W-1:0] entry
);
  logic [OP_W-1:0] tab [NENT];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    always_comb begin
      tab[e] = '0;
      for (int j = 0; j < WIN; j++) begin
        if (((e >> j) & 1) != 0) tab[e] = tab[e] ^ (a_low << j);
      end
    end
  end

  assign entry = tab[sel];
endmodule

// File: rtl/clmul_win32.sv
module clmul_win32 #(
  parameter int unsigned OP_W = 32,
  parameter int unsigned WIN  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic        busy,
  output logic        done,
  output logic [31:0] prod_lo,
  output logic [31:0] prod_hi
);
  localparam int unsigned NSLICE  = clmul_pkg::slice_count(OP_W, WIN);
  localparam int unsigned IDX_W   = $clog2(NSLICE + 1);
  localparam int unsigned ACC_W   = 2 * OP_W;
  localparam int unsigned SH_W    = $clog2(ACC_W);
  localparam int unsigned NCLR    = WIN - 1;
  localparam int unsigned FIX_LSB = OP_W - NCLR;
  localparam logic [OP_W-1:0] KEEP_MASK = {{NCLR{1'b0}}, {FIX_LSB{1'b1}}};

  logic             load, acc_en, fix_en;
  logic [IDX_W-1:0] slice_idx;
  logic [OP_W-1:0]  a_q, b_q, a_d, b_d;
  logic [ACC_W-1:0] acc_q, acc_d, fix_term, placed;
  logic [SH_W-1:0]  shamt;
  logic [WIN-1:0]   sel;
  logic [OP_W-1:0]  entry;

  clmul_ctrl #(.NSLICE(NSLICE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .load(load),
    .acc_en(acc_en), .fix_en(fix_en), .slice_idx(slice_idx)
  );

  assign shamt = SH_W'(slice_idx) * SH_W'(WIN);
  assign sel   = WIN'(b_q >> shamt);

  clmul_wintab #(.OP_W(OP_W), .WIN(WIN)) tab_i (
    .a_low(a_q & KEEP_MASK), .sel(sel), .entry(entry)
  );

  assign placed = {{OP_W{1'b0}}, entry} << shamt;

  always_comb begin
    fix_term = '0;
    for (int j = 0; j < int'(NCLR); j++) begin
      if (a_q[FIX_LSB + j]) fix_term = fix_term ^ ({{OP_W{1'b0}}, b_q} << (FIX_LSB + j));
    end
  end

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    acc_d = acc_q;
    if (load) begin
      a_d   = op_a;
      b_d   = op_b;
      acc_d = '0;
    end else if (acc_en) begin
      acc_d = acc_q ^ placed;
    end else if (fix_en) begin
      acc_d = acc_q ^ fix_term;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      acc_q <= acc_d;
    end
  end

  assign prod_lo = acc_q[OP_W-1:0];
  assign prod_hi = acc_q[ACC_W-1:OP_W];

  p_operands_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(a_q) && $stable(b_q));
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(acc_q));
  p_top_slice_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && slice_idx == IDX_W'(NSLICE - 1)) |-> (sel[WIN-1] == 1'b0 || (NSLICE * WIN == OP_W)));
endmodule

// File: tb/clmul_win32_tb_top.sv
module clmul_win32_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        busy, done;
  logic [31:0] prod_lo, prod_hi;
  int          checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  clmul_win32 dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .prod_lo(prod_lo), .prod_hi(prod_hi)
  );

  function automatic logic [63:0] ref_clmul(logic [31:0] a, logic [31:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 32; i++) if (b[i]) r = r ^ ({32'b0, a} << i);
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // start at negedge; poke=1 re-pulses start with other operands mid-run
  task automatic run_op(logic [31:0] a, logic [31:0] b, string req, bit poke);
    int k = 0;
    logic [63:0] exp = ref_clmul(a, b);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_a = ~a; op_b = b ^ 32'h5a5a_a5a5;   // R5 scramble
    k = 1;
    check("R3 busy after start", {63'b0, busy}, 64'd1);
    while (!done && k < 40) begin
      if (poke && k == 5) begin op_a = 32'hffff_ffff; op_b = 32'h1234_5678; start = 1'b1; end
      else start = 1'b0;
      check("R3 busy/done exclusive", {63'b0, busy & done}, 64'd0);
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check("R2 latency 12 edges", 64'(k), 64'd13);
    check({req, " product"}, {prod_hi, prod_lo}, exp);
    @(negedge clk);
    check("R2 done single cycle", {63'b0, done}, 64'd0);
    check("R3 busy low after done", {63'b0, busy}, 64'd0);
    @(negedge clk);
    check("R10 product held", {prod_hi, prod_lo}, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R9 reset product", {prod_hi, prod_lo}, 64'd0);
    check("R9 reset busy/done", {62'b0, busy, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(32'h0000_0001, 32'h0000_0001, "R1", 1'b0);
    run_op(32'h4000_0000, 32'hdead_beef, "R6", 1'b0);
    run_op(32'h8000_0000, 32'hdead_beef, "R7", 1'b0);
    run_op(32'hc000_0000, 32'hffff_ffff, "R6 R7", 1'b0);
    run_op(32'h3fff_ffff, 32'hc000_0000, "R8", 1'b0);
    run_op(32'hffff_ffff, 32'hffff_ffff, "R1 all ones", 1'b0);
    run_op(32'h0000_0000, 32'h9876_5432, "R1 zero", 1'b0);
    run_op(32'h1357_9bdf, 32'h2468_ace0, "R4", 1'b1);
    for (int i = 0; i < 40; i++) run_op($urandom, $urandom, "R1 random", (i % 7) == 0);
    // R9 mid-operation reset
    op_a = 32'h0f0f_0f0f; op_b = 32'hf0f0_f0f0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 mid-run reset product", {prod_hi, prod_lo}, 64'd0);
    check("R9 mid-run reset busy/done", {62'b0, busy, done}, 64'd0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    run_op(32'hcafe_f00d, 32'h8000_0001, "R1 after reset", 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule